// File: doc/BRIEF.md
# Lane-Banked Operand Register File

This block holds the general-purpose registers of one streaming multiprocessor. It is split into independent 32-bit banks, one for each lane group. All banks see the same register indices and each carries its own lane's data. Every bank has three read ports and one write port, so a multiply-accumulate can fetch all three source operands in one cycle. Read data is registered and appears in the cycle after the indices are presented.

Double-width (64-bit) values are not kept in a wider array. They live in an even/odd pair of 32-bit registers, with the low half in the even register. A 64-bit read takes two of the three read ports: port A reads the even register and port B reads the odd one, which leaves port C for a 32-bit operand. A 64-bit write goes through the single write port in two consecutive cycles, low half first. While the high half is being written, the block shows itself as busy.

After reset the block clears every entry to zero, one entry per cycle, and then raises `ready`. The default depth is scaled down for test. A full-size configuration uses 16 banks of 4096 entries.

Top module: `lane_regfile`

## Requirements
- R1: After reset is released, `ready` is low for exactly DEPTH clock edges and goes high at the DEPTH-th edge. From then on every entry of every bank reads zero until it is written.
- R2: While `ready` is low, write requests have no effect, and all three read outputs are zero in the cycle after each such cycle.
- R3: A 32-bit read returns, one cycle after the indices are presented, the last value written to that entry in each bank. Ports A, B and C are independent, and each bank returns only its own lane's data.
- R4: When a read port addresses the entry that the write port writes in the same cycle, the read returns the newly written data (write-first).
- R5: A 64-bit write request (`wr_wide`=1) with an even index n is accepted when not busy. In that cycle it writes bits [31:0] of each bank's 64-bit lane data to entry n. In the next cycle it writes bits [63:32] to entry n+1, and `busy` is high during exactly that second cycle.
- R6: A write request presented while `busy` is high is ignored.
- R7: A 64-bit write request with an odd index changes no entry and does not raise `busy`. It makes `wr_err` high in the next cycle.
- R8: With `rd_wide`=1 and an even `rd_idx_a`, port A returns entry n and port B returns entry n+1 whatever `rd_idx_b` holds. `rd_pair` carries {port B, port A} for each bank, as 64 bits at offset bank*64. Port C keeps reading `rd_idx_c`.
- R9: With `rd_wide`=1 and an odd `rd_idx_a`, `rd_err` is high in the next cycle and ports A and B (and so `rd_pair`) return zero. Port C is unaffected.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset; starts the clear |
| ready | output | 1 | High once the clear has finished |
| wr_en | input | 1 | Write request |
| wr_wide | input | 1 | Write request is a 64-bit pair write |
| wr_idx | input | IW | Write register index (even for pair writes) |
| wr_data | input | NUM_BANKS*64 | Per-bank lane data at offset bank*64; a 32-bit write uses bits [31:0] |
| busy | output | 1 | High in the cycle the high half of a pair is written |
| wr_err | output | 1 | Odd-index pair write was rejected in the previous cycle |
| rd_wide | input | 1 | Read port A/B as one 64-bit operand |
| rd_idx_a | input | IW | Port A index (pair base when wide) |
| rd_idx_b | input | IW | Port B index (ignored when wide) |
| rd_idx_c | input | IW | Port C index |
| rd_data_a | output | NUM_BANKS*32 | Port A data, bank k at offset k*32 |
| rd_data_b | output | NUM_BANKS*32 | Port B data |
| rd_data_c | output | NUM_BANKS*32 | Port C data |
| rd_pair | output | NUM_BANKS*64 | {B, A} per bank at offset k*64 |
| rd_err | output | 1 | Odd-base pair read was presented in the previous cycle |

## Verification
The properties check the control timing on every cycle:
- the length of the clear and that `ready` stays high afterwards;
- the zeroed outputs before `ready`;
- the one-cycle `busy` window after an accepted pair write;
- the error flags and zeroed ports for odd pair bases.

Data content can only be shown by the bench's directed scenarios, because it depends on write history. These scenarios cover what each bank holds after 32-bit and pair writes, write-first forwarding, the high-half placement, that writes during busy or clear are dropped, and the steering of port B in wide reads.

// File: rtl/lrf_pkg.sv
package lrf_pkg;

   // write-port sequencer phases
   typedef enum logic [1:0] {
      WS_CLEAR = 2'd0,   // sweeping zeros through every entry
      WS_IDLE  = 2'd1,   // accepting requests
      WS_HIGH  = 2'd2    // writing the upper half of a pair
   } wseq_state_e;

   localparam int unsigned RD_PORTS = 3;

endpackage

// File: rtl/lrf_bank.sv
module lrf_bank #(
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned IW        = 6,
   parameter bit          BYPASS_EN = 1'b1
) (
   input  logic                      clk,
   input  logic                      rst_n,
   input  logic                      we,
   input  logic [IW-1:0]             waddr,
   input  logic [DATA_W-1:0]         wdata,
   input  logic [2:0][IW-1:0]        raddr,
   input  logic [2:0]                kill,
   output logic [2:0][DATA_W-1:0]    rdata
);

   logic [DATA_W-1:0] mem [DEPTH];

   always_ff @(posedge clk) begin
      if (we) mem[waddr] <= wdata;
   end

   for (genvar p = 0; p < 3; p++) begin : g_port
      logic              hit;
      logic [DATA_W-1:0] q;

      if (BYPASS_EN) begin : g_fwd
         assign hit = we && (waddr == raddr[p]);
      end else begin : g_nofwd
         assign hit = 1'b0;
      end

      always_ff @(posedge clk or negedge rst_n) begin
         if (!rst_n)       q <= '0;
         else if (kill[p]) q <= '0;
         else if (hit)     q <= wdata;
         else              q <= mem[raddr[p]];
      end

      assign rdata[p] = q;
   end

endmodule

// File: rtl/lrf_wseq.sv
module lrf_wseq
   import lrf_pkg::*;
#(
   parameter int unsigned NUM_BANKS = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEPTH     = 64,
   parameter int unsigned IW        = 6
) (
   input  logic                          clk,
   input  logic                          rst_n,
   input  logic                          wr_en,
   input  logic                          wr_wide,
   input  logic [IW-1:0]                 wr_idx,
   input  logic [NUM_BANKS*2*DATA_W-1:0] wr_data,
   output logic                          ready,
   output logic                          busy,
   output logic                          wr_err,
   output logic                          we,
   output logic [IW-1:0]                 waddr,
   output logic [NUM_BANKS*DATA_W-1:0]   wdata
);

   localparam logic [IW-1:0] LAST_IDX = IW'(DEPTH - 1);

   wseq_state_e                  st;
   logic [IW-1:0]                clr_cnt;
   logic [IW-1:0]                hi_idx;
   logic [NUM_BANKS*DATA_W-1:0]  hi_data;
   logic [NUM_BANKS*DATA_W-1:0]  lo_in;
   logic [NUM_BANKS*DATA_W-1:0]  hi_in;
   logic                         odd_req;
   logic                         pair_req;

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_split
      assign lo_in[k*DATA_W +: DATA_W] = wr_data[k*2*DATA_W +: DATA_W];
      assign hi_in[k*DATA_W +: DATA_W] = wr_data[k*2*DATA_W + DATA_W +: DATA_W];
   end

   assign odd_req  = wr_en && wr_wide && wr_idx[0];
   assign pair_req = wr_en && wr_wide && !wr_idx[0];
   assign ready    = (st != WS_CLEAR);
   assign busy     = (st == WS_HIGH);

   always_comb begin
      we    = 1'b0;
      waddr = wr_idx;
      wdata = lo_in;
      unique case (st)
         WS_CLEAR: begin
            we    = 1'b1;
            waddr = clr_cnt;
            wdata = '0;
         end
         WS_HIGH: begin
            we    = 1'b1;
            waddr = hi_idx;
            wdata = hi_data;
         end
         default: begin
            we = wr_en && !odd_req;
         end
      endcase
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         st      <= WS_CLEAR;
         clr_cnt <= '0;
         hi_idx  <= '0;
         hi_data <= '0;
         wr_err  <= 1'b0;
      end else begin
         wr_err <= (st == WS_IDLE) && odd_req;
         unique case (st)
            WS_CLEAR: begin
               clr_cnt <= clr_cnt + 1'b1;
               if (clr_cnt == LAST_IDX) st <= WS_IDLE;
            end
            WS_HIGH: st <= WS_IDLE;
            default: begin
               if (pair_req) begin
                  st      <= WS_HIGH;
                  hi_idx  <= {wr_idx[IW-1:1], 1'b1};
                  hi_data <= hi_in;
               end
            end
         endcase
      end
   end

endmodule

// File: rtl/lrf_rdaddr.sv
module lrf_rdaddr #(
   parameter int unsigned IW = 6
) (
   input  logic                 ready,
   input  logic                 rd_wide,
   input  logic [IW-1:0]        rd_idx_a,
   input  logic [IW-1:0]        rd_idx_b,
   input  logic [IW-1:0]        rd_idx_c,
   output logic [2:0][IW-1:0]   raddr,
   output logic [2:0]           kill,
   output logic                 err_now
);

   assign err_now  = ready && rd_wide && rd_idx_a[0];
   assign raddr[0] = rd_idx_a;
   assign raddr[1] = rd_wide ? {rd_idx_a[IW-1:1], 1'b1} : rd_idx_b;
   assign raddr[2] = rd_idx_c;
   assign kill[0]  = !ready || err_now;
   assign kill[1]  = !ready || err_now;
   assign kill[2]  = !ready;

endmodule

// File: rtl/lane_regfile.sv
module lane_regfile #(
   parameter int unsigned NUM_BANKS = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEPTH     = 64,
   parameter bit          BYPASS_EN = 1'b1,
   localparam int unsigned IW       = $clog2(DEPTH)
) (
   input  logic                          clk,
   input  logic                          rst_n,
   output logic                          ready,
   input  logic                          wr_en,
   input  logic                          wr_wide,
   input  logic [IW-1:0]                 wr_idx,
   input  logic [NUM_BANKS*2*DATA_W-1:0] wr_data,
   output logic                          busy,
   output logic                          wr_err,
   input  logic                          rd_wide,
   input  logic [IW-1:0]                 rd_idx_a,
   input  logic [IW-1:0]                 rd_idx_b,
   input  logic [IW-1:0]                 rd_idx_c,
   output logic [NUM_BANKS*DATA_W-1:0]   rd_data_a,
   output logic [NUM_BANKS*DATA_W-1:0]   rd_data_b,
   output logic [NUM_BANKS*DATA_W-1:0]   rd_data_c,
   output logic [NUM_BANKS*2*DATA_W-1:0] rd_pair,
   output logic                          rd_err
);

   if (DEPTH < 2 || (DEPTH & (DEPTH - 1)) != 0) begin : g_bad_depth
      $error("DEPTH must be a power of two of at least 2");
   end
   if (NUM_BANKS < 1) begin : g_bad_banks
      $error("NUM_BANKS must be at least 1");
   end
   if (DATA_W < 1) begin : g_bad_width
      $error("DATA_W must be at least 1");
   end

   logic                        we;
   logic [IW-1:0]               waddr;
   logic [NUM_BANKS*DATA_W-1:0] wdata;
   logic [2:0][IW-1:0]          raddr;
   logic [2:0]                  kill;
   logic                        err_now;

   lrf_wseq #(
      .NUM_BANKS (NUM_BANKS),
      .DATA_W    (DATA_W),
      .DEPTH     (DEPTH),
      .IW        (IW)
   ) u_wseq (
      .clk     (clk),
      .rst_n   (rst_n),
      .wr_en   (wr_en),
      .wr_wide (wr_wide),
      .wr_idx  (wr_idx),
      .wr_data (wr_data),
      .ready   (ready),
      .busy    (busy),
      .wr_err  (wr_err),
      .we      (we),
      .waddr   (waddr),
      .wdata   (wdata)
   );

   lrf_rdaddr #(.IW(IW)) u_rdaddr (
      .ready    (ready),
      .rd_wide  (rd_wide),
      .rd_idx_a (rd_idx_a),
      .rd_idx_b (rd_idx_b),
      .rd_idx_c (rd_idx_c),
      .raddr    (raddr),
      .kill     (kill),
      .err_now  (err_now)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) rd_err <= 1'b0;
      else        rd_err <= err_now;
   end

   for (genvar k = 0; k < NUM_BANKS; k++) begin : g_bank
      logic [2:0][DATA_W-1:0] q;

      lrf_bank #(
         .DATA_W    (DATA_W),
         .DEPTH     (DEPTH),
         .IW        (IW),
         .BYPASS_EN (BYPASS_EN)
      ) u_bank (
         .clk   (clk),
         .rst_n (rst_n),
         .we    (we),
         .waddr (waddr),
         .wdata (wdata[k*DATA_W +: DATA_W]),
         .raddr (raddr),
         .kill  (kill),
         .rdata (q)
      );

      assign rd_data_a[k*DATA_W +: DATA_W] = q[0];
      assign rd_data_b[k*DATA_W +: DATA_W] = q[1];
      assign rd_data_c[k*DATA_W +: DATA_W] = q[2];
      assign rd_pair[k*2*DATA_W +: 2*DATA_W] = {q[1], q[0]};
   end

endmodule

// File: rtl/lane_regfile_chk.sv
module lane_regfile_chk #(
   parameter int unsigned NUM_BANKS = 16,
   parameter int unsigned DATA_W    = 32,
   parameter int unsigned DEPTH     = 64,
   localparam int unsigned IW       = $clog2(DEPTH),
   localparam int unsigned CW       = $clog2(DEPTH + 1)
) (
   input logic                        clk,
   input logic                        rst_n,
   input logic                        ready,
   input logic                        busy,
   input logic                        wr_en,
   input logic                        wr_wide,
   input logic [IW-1:0]               wr_idx,
   input logic                        wr_err,
   input logic                        rd_wide,
   input logic [IW-1:0]               rd_idx_a,
   input logic                        rd_err,
   input logic [NUM_BANKS*DATA_W-1:0] rd_data_a,
   input logic [NUM_BANKS*DATA_W-1:0] rd_data_b,
   input logic [NUM_BANKS*DATA_W-1:0] rd_data_c
);

   // edges since reset release, saturating at DEPTH
   logic [CW-1:0] edges;
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)                     edges <= '0;
      else if (edges != CW'(DEPTH))   edges <= edges + 1'b1;
   end

   a_r1_clear_len: assert property (@(posedge clk) disable iff (!rst_n)
      ready == (edges == CW'(DEPTH)));

   a_r1_ready_holds: assert property (@(posedge clk) disable iff (!rst_n)
      ready |=> ready);

   a_r2_zero_before_ready: assert property (@(posedge clk) disable iff (!rst_n)
      !ready |=> (rd_data_a == '0 && rd_data_b == '0 && rd_data_c == '0));

   a_r5_busy_after_pair: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !busy && wr_en && wr_wide && !wr_idx[0]) |=> busy);

   a_r5_busy_single: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> !busy);

   a_r7_odd_write: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && !busy && wr_en && wr_wide && wr_idx[0]) |=> (wr_err && !busy));

   a_r9_odd_read: assert property (@(posedge clk) disable iff (!rst_n)
      (ready && rd_wide && rd_idx_a[0]) |=> (rd_err && rd_data_a == '0 && rd_data_b == '0));

   a_r9_no_spurious_err: assert property (@(posedge clk) disable iff (!rst_n)
      !(ready && rd_wide && rd_idx_a[0]) |=> !rd_err);

endmodule

bind lane_regfile lane_regfile_chk #(
   .NUM_BANKS (NUM_BANKS),
   .DATA_W    (DATA_W),
   .DEPTH     (DEPTH)
) u_chk (
   .clk       (clk),
   .rst_n     (rst_n),
   .ready     (ready),
   .busy      (busy),
   .wr_en     (wr_en),
   .wr_wide   (wr_wide),
   .wr_idx    (wr_idx),
   .wr_err    (wr_err),
   .rd_wide   (rd_wide),
   .rd_idx_a  (rd_idx_a),
   .rd_err    (rd_err),
   .rd_data_a (rd_data_a),
   .rd_data_b (rd_data_b),
   .rd_data_c (rd_data_c)
);

// File: tb/lane_regfile_bench.sv
module lane_regfile_bench;

   localparam int NB    = 16;
   localparam int DW    = 32;
   localparam int DEPTH = 64;
   localparam int IW    = $clog2(DEPTH);

   logic              clk = 1'b0;
   logic              rst_n = 1'b0;
   logic              ready, busy, wr_err, rd_err;
   logic              wr_en = 1'b0, wr_wide = 1'b0, rd_wide = 1'b0;
   logic [IW-1:0]     wr_idx = '0, rd_idx_a = '0, rd_idx_b = '0, rd_idx_c = '0;
   logic [NB*64-1:0]  wr_data = '0;
   logic [NB*32-1:0]  rd_data_a, rd_data_b, rd_data_c;
   logic [NB*64-1:0]  rd_pair;

   int n_chk  = 0;
   int n_fail = 0;

   always #10 clk = ~clk;   // 50 MHz

   lane_regfile #(.NUM_BANKS(NB), .DATA_W(DW), .DEPTH(DEPTH)) u_lane_regfile (
      .clk(clk), .rst_n(rst_n), .ready(ready),
      .wr_en(wr_en), .wr_wide(wr_wide), .wr_idx(wr_idx), .wr_data(wr_data),
      .busy(busy), .wr_err(wr_err),
      .rd_wide(rd_wide), .rd_idx_a(rd_idx_a), .rd_idx_b(rd_idx_b), .rd_idx_c(rd_idx_c),
      .rd_data_a(rd_data_a), .rd_data_b(rd_data_b), .rd_data_c(rd_data_c),
      .rd_pair(rd_pair), .rd_err(rd_err)
   );

   function automatic logic [31:0] pat(input int b, input int idx, input logic [7:0] salt);
      return {salt, 8'(b), 8'hC3, 8'(idx)};
   endfunction

   task automatic chk(input string req, input string what,
                      input logic [63:0] act, input logic [63:0] exp);
      n_chk++;
      if (act !== exp) begin
         n_fail++;
         $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
      end
   endtask

   task automatic report();
      $display("%0d/%0d checks passed", n_chk - n_fail, n_chk);
   endtask

   // one clock: inputs already driven at a falling edge, sample at the next one
   task automatic tick();
      @(posedge clk);
      @(negedge clk);
   endtask

   task automatic write32(input int idx, input logic [7:0] salt);
      wr_en = 1'b1; wr_wide = 1'b0; wr_idx = IW'(idx);
      for (int b = 0; b < NB; b++) wr_data[b*64 +: 64] = {32'hDEAD_0000, pat(b, idx, salt)};
      tick();
      wr_en = 1'b0;
   endtask

   task automatic read3(input logic wide, input int a, input int b, input int c);
      rd_wide = wide; rd_idx_a = IW'(a); rd_idx_b = IW'(b); rd_idx_c = IW'(c);
      tick();
   endtask

   task automatic t_reset_clear();
      wr_en = 1'b1; wr_idx = IW'(3);
      for (int b = 0; b < NB; b++) wr_data[b*64 +: 64] = 64'h1111_2222_3333_4444;
      rd_idx_c = IW'(3);
      @(negedge clk);
      rst_n = 1'b1;
      for (int k = 1; k <= DEPTH; k++) begin
         tick();
         if (k == 1 || k == DEPTH - 1) begin
            chk("R1", "ready during clear", 64'(ready), 64'd0);
            chk("R2", "port C during clear", 64'(rd_data_c[31:0]), 64'd0);
         end
         if (k == DEPTH) chk("R1", "ready after clear", 64'(ready), 64'd1);
      end
      wr_en = 1'b0;
      read3(1'b0, 3, 40, DEPTH - 1);
      for (int b = 0; b < NB; b++) begin
         chk("R2", "entry 3 untouched by early write", 64'(rd_data_a[b*32 +: 32]), 64'd0);
         chk("R1", "entry 40 cleared", 64'(rd_data_b[b*32 +: 32]), 64'd0);
         chk("R1", "last entry cleared", 64'(rd_data_c[b*32 +: 32]), 64'd0);
      end
   endtask

   task automatic t_narrow();
      write32(4, 8'h41);
      write32(5, 8'h52);
      write32(6, 8'h63);
      read3(1'b0, 4, 5, 6);
      for (int b = 0; b < NB; b++) begin
         chk("R3", "port A", 64'(rd_data_a[b*32 +: 32]), 64'(pat(b, 4, 8'h41)));
         chk("R3", "port B", 64'(rd_data_b[b*32 +: 32]), 64'(pat(b, 5, 8'h52)));
         chk("R3", "port C", 64'(rd_data_c[b*32 +: 32]), 64'(pat(b, 6, 8'h63)));
      end
      read3(1'b0, 6, 4, 5);
      chk("R3", "reordered port A bank 0", 64'(rd_data_a[31:0]), 64'(pat(0, 6, 8'h63)));
      chk("R3", "reordered port C last bank", 64'(rd_data_c[(NB-1)*32 +: 32]),
          64'(pat(NB - 1, 5, 8'h52)));
   endtask

   task automatic t_bypass();
      wr_en = 1'b1; wr_wide = 1'b0; wr_idx = IW'(10);
      for (int b = 0; b < NB; b++) wr_data[b*64 +: 64] = {32'h0, pat(b, 10, 8'hB7)};
      rd_wide = 1'b0; rd_idx_a = IW'(10); rd_idx_b = IW'(4); rd_idx_c = IW'(10);
      tick();
      wr_en = 1'b0;
      for (int b = 0; b < NB; b++) begin
         chk("R4", "port A same-cycle", 64'(rd_data_a[b*32 +: 32]), 64'(pat(b, 10, 8'hB7)));
         chk("R4", "port C same-cycle", 64'(rd_data_c[b*32 +: 32]), 64'(pat(b, 10, 8'hB7)));
      end
      chk("R4", "other port unaffected", 64'(rd_data_b[31:0]), 64'(pat(0, 4, 8'h41)));
   endtask

   task automatic t_pair_write();
      wr_en = 1'b1; wr_wide = 1'b1; wr_idx = IW'(8);
      for (int b = 0; b < NB; b++) wr_data[b*64 +: 64] = {pat(b, 9, 8'hE9), pat(b, 8, 8'hE8)};
      tick();
      chk("R5", "busy in high-half cycle", 64'(busy), 64'd1);
      wr_wide = 1'b0; wr_idx = IW'(12);
      for (int b = 0; b < NB; b++) wr_data[b*64 +: 64] = 64'hBAD0_BAD0_BAD0_BAD0;
      rd_idx_b = IW'(9);
      tick();
      wr_en = 1'b0;
      chk("R5", "busy cleared", 64'(busy), 64'd0);
      chk("R4", "high half forwarded", 64'(rd_data_b[31:0]), 64'(pat(0, 9, 8'hE9)));
      read3(1'b0, 8, 9, 12);
      for (int b = 0; b < NB; b++) begin
         chk("R5", "low half at even", 64'(rd_data_a[b*32 +: 32]), 64'(pat(b, 8, 8'hE8)));
         chk("R5", "high half at odd", 64'(rd_data_b[b*32 +: 32]), 64'(pat(b, 9, 8'hE9)));
         chk("R6", "write during busy dropped", 64'(rd_data_c[b*32 +: 32]), 64'd0);
      end
   endtask

   task automatic t_odd_write();
      write32(14, 8'h14);
      write32(15, 8'h15);
      wr_en = 1'b1; wr_wide = 1'b1; wr_idx = IW'(15);
      for (int b = 0; b < NB; b++) wr_data[b*64 +: 64] = 64'hFEED_FEED_FEED_FEED;
      tick();
      wr_en = 1'b0; wr_wide = 1'b0;
      chk("R7", "wr_err", 64'(wr_err), 64'd1);
      chk("R7", "no busy", 64'(busy), 64'd0);
      read3(1'b0, 14, 15, 16);
      chk("R7", "wr_err drops", 64'(wr_err), 64'd0);
      for (int b = 0; b < NB; b++) begin
         chk("R7", "entry 14 kept", 64'(rd_data_a[b*32 +: 32]), 64'(pat(b, 14, 8'h14)));
         chk("R7", "entry 15 kept", 64'(rd_data_b[b*32 +: 32]), 64'(pat(b, 15, 8'h15)));
         chk("R7", "entry 16 kept", 64'(rd_data_c[b*32 +: 32]), 64'd0);
      end
   endtask

   task automatic t_pair_read();
      read3(1'b1, 8, 20, 4);
      chk("R8", "rd_err low", 64'(rd_err), 64'd0);
      for (int b = 0; b < NB; b++) begin
         chk("R8", "port A even", 64'(rd_data_a[b*32 +: 32]), 64'(pat(b, 8, 8'hE8)));
         chk("R8", "port B odd", 64'(rd_data_b[b*32 +: 32]), 64'(pat(b, 9, 8'hE9)));
         chk("R8", "pair", rd_pair[b*64 +: 64], {pat(b, 9, 8'hE9), pat(b, 8, 8'hE8)});
         chk("R8", "port C free", 64'(rd_data_c[b*32 +: 32]), 64'(pat(b, 4, 8'h41)));
      end
   endtask

   task automatic t_odd_read();
      read3(1'b1, 9, 4, 5);
      chk("R9", "rd_err", 64'(rd_err), 64'd1);
      for (int b = 0; b < NB; b++) begin
         chk("R9", "port A zero", 64'(rd_data_a[b*32 +: 32]), 64'd0);
         chk("R9", "port B zero", 64'(rd_data_b[b*32 +: 32]), 64'd0);
         chk("R9", "pair zero", rd_pair[b*64 +: 64], 64'd0);
         chk("R9", "port C unaffected", 64'(rd_data_c[b*32 +: 32]), 64'(pat(b, 5, 8'h52)));
      end
      read3(1'b0, 4, 5, 6);
      chk("R9", "rd_err clears", 64'(rd_err), 64'd0);
   endtask

   initial begin
      repeat (20000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual timeout expected completion");
      report();
      $finish;
   end

   initial begin
      repeat (3) @(negedge clk);
      t_reset_clear();
      t_narrow();
      t_bypass();
      t_pair_write();
      t_odd_write();
      t_pair_read();
      t_odd_read();
      report();
      $finish;
   end

endmodule